// File: doc/BRIEF.md
# Interrupt CPU Interface with Split Completion

This block is the processor-facing half of a small interrupt controller. Interrupt sources mark IDs as pending through a set vector. Each ID has an 8-bit priority, where a lower value is more urgent. The processor works through a memory-mapped register window. Reading the acknowledge register takes the most urgent eligible interrupt. That interrupt becomes active and its priority becomes the running priority. An IRQ output tells the processor that an acknowledge would succeed right now.

Completion works in one of two ways, selected by a control bit:

- **Combined mode.** One end-of-interrupt write does two things: it lowers the running priority and it releases the interrupt.
- **Split mode.** The end-of-interrupt write only lowers the running priority. A second write, to a deactivate register, releases the interrupt. Between the two writes, other interrupts at the same level can be taken. The dropped ID itself stays blocked until it is deactivated.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, control and mask read 0, the error flag reads 0, the running priority (offset 0x014) reads 0xFF, `irq_out` is low and an acknowledge read returns 1023.
- R2: A read of the acknowledge register (offset 0x00C) returns the pending, non-active ID with the numerically lowest priority, with ties going to the lowest ID. The read moves that ID from pending to active and pushes its priority as the running priority.
- R3: `irq_out` is high only when all of these hold:
  - control bit 0 is set;
  - the best eligible priority is below the mask (offset 0x004);
  - the best eligible priority is below the running priority.
  In every other case an acknowledge read returns 1023 and changes nothing.
- R4: With control bit 9 clear, an end-of-interrupt write (offset 0x010) restores the previous running priority and clears the written ID's active state.
- R5: With control bit 9 set, an end-of-interrupt write only restores the previous running priority. The written ID stays active and cannot be acknowledged again, while other IDs of the same priority can be.
- R6: With control bit 9 set, a write to the deactivate register (offset 0x1000) clears the written ID's active state, so the ID can be taken again.
- R7: A deactivate write while control bit 9 is clear leaves every active state unchanged. It also sets a sticky error flag, read at bit 0 of offset 0x01C and cleared by any write to that offset.
- R8: IDs occupy bits 9:0 of the acknowledge, end-of-interrupt and deactivate registers. Upper write bits are ignored, and acknowledge reads return zero in bits 31:10.
- R9: IDs 0 to 15 (inter-processor interrupts) follow exactly the same acknowledge and completion rules as the other IDs.
- R10: The control register (offset 0x000) keeps bit 0 (enable) and bit 9 (split mode) and reads other bits as 0. The mask register keeps bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | NUM_IRQ | One-cycle pulse per ID that marks it pending |
| src_prio | input | NUM_IRQ*8 | Priority of each ID, ID i in bits [8i+7:8i] |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset within the 8 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the strobe cycle |
| irq_out | output | 1 | An acknowledge would return a real ID |

## Verification
The bench sweeps every ID one at a time. It then pends all IDs together and drains them. It predicts the acknowledge order by sorting on priority and then ID, so a selector that breaks ties toward the higher ID, or that lets masked priorities through, gives the wrong sequence.

The nesting cases check that an equal-priority interrupt waits behind the running priority but a more urgent one preempts it. A design that compares with less-or-equal would signal too early.

In split mode, the bench re-pends an ID after its end-of-interrupt write. A design that deactivated on that write would hand the ID out again.

A deactivate write in combined mode must leave the ID blocked and raise the error flag. A design that honoured the write would release the interrupt.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;

  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 13'h000;
  localparam logic [ADDR_W-1:0] OFF_PMASK = 13'h004;
  localparam logic [ADDR_W-1:0] OFF_ACK   = 13'h00C;
  localparam logic [ADDR_W-1:0] OFF_EOI   = 13'h010;
  localparam logic [ADDR_W-1:0] OFF_RUN   = 13'h014;
  localparam logic [ADDR_W-1:0] OFF_ERR   = 13'h01C;
  localparam logic [ADDR_W-1:0] OFF_DEACT = 13'h1000;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_SPLIT_BIT = 9;

  typedef struct packed {
    logic              valid;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } cand_t;
endpackage

// File: rtl/irq_cpu_if_select.sv
module irq_cpu_if_select
  import irq_cpu_if_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output cand_t               best
);
  // Linear scan; strict compare keeps the lowest ID on equal priority.
  always_comb begin
    best.valid = 1'b0;
    best.id    = '0;
    best.prio  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!best.valid || (prio_flat[i*PRIO_W +: PRIO_W] < best.prio))) begin
        best.valid = 1'b1;
        best.id    = ID_W'(i);
        best.prio  = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_cpu_if_stack.sv
module irq_cpu_if_stack
  import irq_cpu_if_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [PRIO_W-1:0] top_prio,
  output logic              full,
  output logic              empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [PRIO_W-1:0] ent_q [DEPTH];
  logic              do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + 1'b1;
    else if (do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic ld;
    assign ld = do_push && (cnt_q == CW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[k] <= '0;
      else if (ld) ent_q[k] <= push_prio;
    end
  end

  // Idle running priority is all ones.
  always_comb begin
    top_prio = '1;
    for (int k = 0; k < DEPTH; k++) begin
      if (cnt_q == CW'(k + 1)) top_prio = ent_q[k];
    end
  end
endmodule

// File: rtl/irq_cpu_if_state.sv
module irq_cpu_if_state
  import irq_cpu_if_pkg::*;
#(
  parameter int N = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    set_vec,
  input  logic            take,
  input  logic [ID_W-1:0] take_id,
  input  logic            release_en,
  input  logic [ID_W-1:0] release_id,
  output logic [N-1:0]    pending,
  output logic [N-1:0]    active
);
  for (genvar i = 0; i < N; i++) begin : g_id
    logic hit_take, hit_rel, pend_d, act_d;
    assign hit_take = take && (take_id == ID_W'(i));
    assign hit_rel  = release_en && (release_id == ID_W'(i));

    always_comb begin
      pend_d = set_vec[i] | (pending[i] & ~hit_take);
      act_d  = (active[i] | hit_take) & ~hit_rel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
        active[i]  <= 1'b0;
      end else begin
        pending[i] <= pend_d;
        active[i]  <= act_d;
      end
    end
  end
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int STACK_DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        src_set,
  input  logic [NUM_IRQ*PRIO_W-1:0] src_prio,
  input  logic                      bus_en,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      irq_out
);
  logic              ctrl_en_q, ctrl_en_d, ctrl_split_q, ctrl_split_d;
  logic [PRIO_W-1:0] pmask_q, pmask_d;
  logic              err_q, err_d;
  logic [NUM_IRQ-1:0] pend_vec, act_vec;
  cand_t             hp;
  logic [PRIO_W-1:0] run_prio;
  logic              stk_full, stk_empty;
  logic              wr, rd;
  logic              wr_ctrl, wr_pmask, wr_eoi, wr_deact, wr_err, rd_ack;
  logic              signal_ok, ack_take, rel_en;
  logic [ID_W-1:0]   wid, ack_id;
  logic              unused_wdata;

  assign wr  = bus_en && bus_we;
  assign rd  = bus_en && !bus_we;
  assign wid = bus_wdata[ID_W-1:0];
  assign unused_wdata = ^bus_wdata[DATA_W-1:ID_W];

  assign wr_ctrl  = wr && (bus_addr == OFF_CTRL);
  assign wr_pmask = wr && (bus_addr == OFF_PMASK);
  assign wr_eoi   = wr && (bus_addr == OFF_EOI);
  assign wr_deact = wr && (bus_addr == OFF_DEACT);
  assign wr_err   = wr && (bus_addr == OFF_ERR);
  assign rd_ack   = rd && (bus_addr == OFF_ACK);

  irq_cpu_if_select #(.N(NUM_IRQ)) u_sel (
    .elig      (pend_vec & ~act_vec),
    .prio_flat (src_prio),
    .best      (hp)
  );

  assign signal_ok = ctrl_en_q && hp.valid && (hp.prio < pmask_q) &&
                     (hp.prio < run_prio) && !stk_full;
  assign irq_out   = signal_ok;
  assign ack_id    = signal_ok ? hp.id : ID_NONE;
  assign ack_take  = rd_ack && signal_ok;

  // Release: combined-mode EOI, or split-mode deactivate.
  assign rel_en = (wr_eoi && !ctrl_split_q) || (wr_deact && ctrl_split_q);

  irq_cpu_if_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_take),
    .pop       (wr_eoi),
    .push_prio (hp.prio),
    .top_prio  (run_prio),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  irq_cpu_if_state #(.N(NUM_IRQ)) u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (src_set),
    .take       (ack_take),
    .take_id    (hp.id),
    .release_en (rel_en),
    .release_id (wid),
    .pending    (pend_vec),
    .active     (act_vec)
  );

  always_comb begin
    ctrl_en_d    = ctrl_en_q;
    ctrl_split_d = ctrl_split_q;
    pmask_d      = pmask_q;
    err_d        = err_q;
    if (wr_ctrl) begin
      ctrl_en_d    = bus_wdata[CTRL_EN_BIT];
      ctrl_split_d = bus_wdata[CTRL_SPLIT_BIT];
    end
    if (wr_pmask) pmask_d = bus_wdata[PRIO_W-1:0];
    if (wr_err)   err_d   = 1'b0;
    if (wr_deact && !ctrl_split_q) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q    <= 1'b0;
      ctrl_split_q <= 1'b0;
      pmask_q      <= '0;
      err_q        <= 1'b0;
    end else begin
      ctrl_en_q    <= ctrl_en_d;
      ctrl_split_q <= ctrl_split_d;
      pmask_q      <= pmask_d;
      err_q        <= err_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL: begin
        bus_rdata[CTRL_EN_BIT]    = ctrl_en_q;
        bus_rdata[CTRL_SPLIT_BIT] = ctrl_split_q;
      end
      OFF_PMASK: bus_rdata[PRIO_W-1:0] = pmask_q;
      OFF_ACK:   bus_rdata[ID_W-1:0]   = ack_id;
      OFF_RUN:   bus_rdata[PRIO_W-1:0] = run_prio;
      OFF_ERR:   bus_rdata[0]          = err_q;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_cpu_if_checker.sv
module irq_cpu_if_checker
  import irq_cpu_if_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic              ctrl_en,
  input logic              ctrl_split,
  input logic              err_flag,
  input logic [N-1:0]      active
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic          ack_rd, eoi_wr, deact_wr, id_ok;
  logic [IW-1:0] widx, ridx;

  assign ack_rd   = bus_en && !bus_we && (bus_addr == OFF_ACK);
  assign eoi_wr   = bus_en && bus_we && (bus_addr == OFF_EOI);
  assign deact_wr = bus_en && bus_we && (bus_addr == OFF_DEACT);
  assign id_ok    = (bus_wdata[ID_W-1:0] < ID_W'(N));
  assign widx     = bus_wdata[IW-1:0];
  assign ridx     = bus_rdata[IW-1:0];

  p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ctrl_en);

  p_ack_idle_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !irq_out) |-> (bus_rdata == DATA_W'(ID_NONE)));

  p_ack_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd |-> (bus_rdata[DATA_W-1:ID_W] == '0));

  p_ack_makes_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && irq_out) |=> active[$past(ridx)]);

  p_combined_eoi_releases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !ctrl_split && id_ok) |=> !active[$past(widx)]);

  p_split_eoi_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && ctrl_split && id_ok && active[widx]) |=> active[$past(widx)]);

  p_deact_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_wr && ctrl_split && id_ok) |=> !active[$past(widx)]);

  p_bad_deact_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_wr && !ctrl_split) |=> (err_flag && $stable(active)));
endmodule

bind irq_cpu_if irq_cpu_if_checker #(.N(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_out    (irq_out),
  .ctrl_en    (ctrl_en_q),
  .ctrl_split (ctrl_split_q),
  .err_flag   (err_q),
  .active     (act_vec)
);

// File: tb/test_irq_cpu_if.sv
module test_irq_cpu_if;
  import irq_cpu_if_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic                 clk, rst_n;
  logic [N-1:0]         src_set;
  logic [N*PRIO_W-1:0]  src_prio;
  logic                 bus_en, bus_we;
  logic [ADDR_W-1:0]    bus_addr;
  logic [DATA_W-1:0]    bus_wdata, bus_rdata;
  logic                 irq_out;
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  irq_cpu_if #(.NUM_IRQ(N), .STACK_DEPTH(8)) i_irq_cpu_if (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_prio(src_prio),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] prio_of(int i);
    return 8'(((i * 7) % 16) << 4);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(logic [ADDR_W-1:0] a, logic [31:0] exp, string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic pend(logic [N-1:0] v);
    @(negedge clk);
    src_set = v;
    @(posedge clk); #1;
    src_set = '0;
  endtask

  task automatic irq_chk(logic exp, string req);
    @(negedge clk);
    chk(irq_out == exp, req, 32'(irq_out), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit pm [N];
    for (int i = 0; i < N; i++) src_prio[i*PRIO_W +: PRIO_W] = prio_of(i);
    rst_n = 1'b0; src_set = '0; bus_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd_chk(OFF_CTRL, 32'h0, "R1 ctrl");
    rd_chk(OFF_PMASK, 32'h0, "R1 mask");
    rd_chk(OFF_ERR, 32'h0, "R1 err");
    rd_chk(OFF_RUN, 32'hFF, "R1 running");
    irq_chk(1'b0, "R1 irq");
    rd_chk(OFF_ACK, 32'd1023, "R1 ack");

    // R10 register readback
    wr(OFF_CTRL, 32'hFFFF_FDFF);
    rd_chk(OFF_CTRL, 32'h1, "R10 ctrl");
    wr(OFF_PMASK, 32'h1234_56F0);
    rd_chk(OFF_PMASK, 32'hF0, "R10 mask");

    // R9 / R2 / R4 sweep of every ID, combined mode
    for (int i = 0; i < N; i++) begin
      bit ok;
      ok = prio_of(i) < 8'hF0;
      pend(N'(1) << i);
      irq_chk(ok, "R3 sweep irq");
      rd_chk(OFF_ACK, ok ? 32'(i) : 32'd1023, i < 16 ? "R9 sweep ack" : "R2 sweep ack");
      if (ok) begin
        rd_chk(OFF_RUN, 32'(prio_of(i)), "R2 running push");
        wr(OFF_EOI, 32'(i));
        rd_chk(OFF_RUN, 32'hFF, "R4 running drop");
        pend(N'(1) << i);
        rd_chk(OFF_ACK, 32'(i), "R4 retake after eoi");
        wr(OFF_EOI, 32'(i));
      end
    end

    // R2 order when all pend together
    pend('1);
    for (int i = 0; i < N; i++) pm[i] = 1'b1;
    for (int s = 0; s < N + 1; s++) begin
      int best;
      best = -1;
      for (int i = 0; i < N; i++)
        if (pm[i] && prio_of(i) < 8'hF0 && (best < 0 || prio_of(i) < prio_of(best))) best = i;
      rd(OFF_ACK, d);
      if (best < 0) begin
        chk(d == 32'd1023, "R2 drain end", d, 32'd1023);
        break;
      end
      chk(d == 32'(best), "R2 order", d, 32'(best));
      pm[best] = 1'b0;
      wr(OFF_EOI, d);
    end

    // R3 nesting
    pend(N'(1) << 3);
    rd_chk(OFF_ACK, 32'd3, "R3 take 3");
    pend(N'(1) << 19);
    irq_chk(1'b0, "R3 equal level blocked");
    rd_chk(OFF_ACK, 32'd1023, "R3 equal level ack");
    pend(N'(1) << 0);
    irq_chk(1'b1, "R3 preempt irq");
    rd_chk(OFF_ACK, 32'd0, "R3 preempt ack");
    rd_chk(OFF_RUN, 32'h00, "R3 running nested");
    wr(OFF_EOI, 32'd0);
    rd_chk(OFF_RUN, 32'h50, "R4 running restored");
    rd_chk(OFF_ACK, 32'd1023, "R3 still blocked");
    wr(OFF_EOI, 32'd3);
    rd_chk(OFF_ACK, 32'd19, "R3 released");
    wr(OFF_EOI, 32'd19);

    // R3 mask
    wr(OFF_PMASK, 32'h50);
    pend(N'(1) << 3);
    irq_chk(1'b0, "R3 mask equal blocks");
    rd_chk(OFF_ACK, 32'd1023, "R3 mask ack");
    wr(OFF_PMASK, 32'hF0);
    rd_chk(OFF_ACK, 32'd3, "R3 mask raised");
    wr(OFF_EOI, 32'd3);

    // R5 / R6 split mode
    wr(OFF_CTRL, 32'h201);
    rd_chk(OFF_CTRL, 32'h201, "R10 ctrl split");
    pend((N'(1) << 3) | (N'(1) << 19));
    rd_chk(OFF_ACK, 32'd3, "R5 take 3");
    wr(OFF_EOI, 32'd3);
    rd_chk(OFF_RUN, 32'hFF, "R5 drop");
    irq_chk(1'b1, "R5 same level irq");
    rd_chk(OFF_ACK, 32'd19, "R5 same level ack");
    wr(OFF_EOI, 32'd19);
    wr(OFF_DEACT, 32'd19);
    pend(N'(1) << 3);
    irq_chk(1'b0, "R5 dropped id blocked");
    rd_chk(OFF_ACK, 32'd1023, "R5 dropped id ack");
    wr(OFF_DEACT, 32'hFFFF_FC03);
    irq_chk(1'b1, "R8 deact upper bits");
    rd_chk(OFF_ACK, 32'd3, "R6 retake");
    wr(OFF_EOI, 32'd3);
    wr(OFF_DEACT, 32'd3);
    rd_chk(OFF_ERR, 32'h0, "R6 no err");

    // R7 deactivate in combined mode
    pend(N'(1) << 5);
    rd_chk(OFF_ACK, 32'd5, "R7 take 5");
    wr(OFF_EOI, 32'd5);
    wr(OFF_CTRL, 32'h1);
    wr(OFF_DEACT, 32'd5);
    rd_chk(OFF_ERR, 32'h1, "R7 err set");
    pend(N'(1) << 5);
    rd_chk(OFF_ACK, 32'd1023, "R7 no effect");
    wr(OFF_CTRL, 32'h201);
    wr(OFF_DEACT, 32'd5);
    rd_chk(OFF_ACK, 32'd5, "R6 after mode change");
    wr(OFF_EOI, 32'd5);
    wr(OFF_DEACT, 32'd5);
    rd_chk(OFF_ERR, 32'h1, "R7 sticky");
    wr(OFF_ERR, 32'h0);
    rd_chk(OFF_ERR, 32'h0, "R7 clear");

    // R8 upper EOI bits ignored in combined mode
    wr(OFF_CTRL, 32'h1);
    pend(N'(1) << 6);
    rd_chk(OFF_ACK, 32'd6, "R8 take 6");
    wr(OFF_EOI, 32'h8000_0006);
    pend(N'(1) << 6);
    rd_chk(OFF_ACK, 32'd6, "R8 eoi upper bits");
    wr(OFF_EOI, 32'd6);

    // R3 disable
    wr(OFF_CTRL, 32'h0);
    pend(N'(1) << 3);
    irq_chk(1'b0, "R3 disabled irq");
    rd_chk(OFF_ACK, 32'd1023, "R3 disabled ack");
    wr(OFF_CTRL, 32'h1);
    rd_chk(OFF_ACK, 32'd3, "R3 enabled ack");
    wr(OFF_EOI, 32'd3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule